// File: doc/BRIEF.md
# Audio FIFO Error Status Logic

This block sits between a processor register port and the two data paths of a serial audio port. The processor writes outgoing words into an 8-word transmit queue, and the serial side takes them out one at a time. Incoming serial words land first in a one-word holding buffer. From there they move into an 8-word receive queue, which the processor reads.

Three misuse conditions are caught: the processor writing to a full transmit queue, the processor reading an empty receive queue, and a serial word arriving while the holding buffer still has an undelivered word. Each condition latches its own sticky flag. The processor clears a flag by writing a 0 to its bit. A per-flag enable mask decides which latched flags drive the single interrupt line. The serial side is modelled as one-cycle word strobes.

Top module: `audio_err_stat`

## Requirements
- R1: After a synchronous active-low reset, `stat_rdata` reads 0 (all flags clear, both counts 0), `irq` is 0, `ser_tx_valid` is 0 and the enable mask is 0.
- R2: The transmit queue keeps up to 8 words in arrival order. `ser_tx_data` shows the oldest word and `ser_tx_valid` is 1 while the count is nonzero. A `ser_tx_pop` removes the oldest word. The count updates on the clock edge after the strobe.
- R3: A `cpu_tx_wr` while the transmit count is 8 sets flag bit 0 (transmit overflow). The written word is discarded and the stored words are left unchanged. The count drops only through a simultaneous pop.
- R4: A `cpu_rx_rd` while the receive count is 0 sets flag bit 1 (receive underflow). The receive count and contents do not change.
- R5: A serial word arrives on `ser_rx_push` and enters the holding buffer. The buffer moves a word into the receive queue on the next edge at which the queue is not full. If a new word arrives while the buffer holds a word that cannot move (queue full), flag bit 2 (receive overflow) is set and the new word replaces the buffered one.
- R6: Each flag sets whatever the value of its enable bit.
- R7: A write on `cpu_flag_wr` clears each flag whose `cpu_flag_wdata` bit is 0 and leaves each flag whose bit is 1 unchanged. No other action clears a flag.
- R8: If a flag's error event occurs in the same cycle as a write-0 clear of that flag, the flag is 1 afterwards.
- R9: `irq` is 1 exactly while some flag bit and the matching `irq_en` bit (loaded by `cpu_en_wr` from `cpu_en_wdata`, same bit order) are both 1.
- R10: `stat_rdata` layout: bits [2:0] are the flags (bit 0 transmit overflow, bit 1 receive underflow, bit 2 receive overflow), bit 3 is 0, bits [7:4] hold the transmit count, bits [11:8] hold the receive count.
- R11: Received words reach the processor in arrival order. `cpu_rx_data` shows the oldest queued word, and a `cpu_rx_rd` with a nonzero count removes it. A word strobed in appears in the receive count two edges later when the queue has room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_tx_wr | input | 1 | Processor write strobe for the transmit data register |
| cpu_tx_data | input | 16 | Transmit word written by the processor |
| cpu_rx_rd | input | 1 | Processor read strobe for the receive data register |
| cpu_rx_data | output | 16 | Oldest word in the receive queue |
| cpu_flag_wr | input | 1 | Write strobe for the flag bits |
| cpu_flag_wdata | input | 3 | Flag write value; 0 clears, 1 keeps |
| cpu_en_wr | input | 1 | Write strobe for the enable mask |
| cpu_en_wdata | input | 3 | New enable mask |
| stat_rdata | output | 12 | Flags and both queue counts |
| irq | output | 1 | Interrupt request |
| ser_tx_pop | input | 1 | Serial side takes one transmit word |
| ser_tx_data | output | 16 | Oldest transmit word |
| ser_tx_valid | output | 1 | Transmit queue not empty |
| ser_rx_push | input | 1 | Serial side delivers one received word |
| ser_rx_data | input | 16 | Received word |

## Verification
A flag, a transmit count and the transmit head change on the first clock edge after their strobe. `irq` follows the flags with no further delay. A received word spends one edge in the holding buffer and becomes visible in the receive count and on `cpu_rx_data` after the second edge. The bench drives every strobe at a falling edge and advances a reference model at the following rising edge. It compares all outputs at the next falling edge, so each check lands after exactly the edges the requirements count.

// File: rtl/afe_pkg.sv
package afe_pkg;
  localparam int NFLAG   = 3;
  localparam int F_TXOVF = 0;
  localparam int F_RXUDF = 1;
  localparam int F_RXOVF = 2;

  function automatic int cnt_width(input int depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/afe_fifo.sv
module afe_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= ptr_step(wptr);
      if (do_pop)  rptr <= ptr_step(rptr);
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R2
  AST_FULL_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full); // R3
endmodule

// File: rtl/afe_rx_buf.sv
module afe_rx_buf #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_push,
  input  logic [W-1:0] in_data,
  input  logic         q_full,
  output logic         out_push,
  output logic [W-1:0] out_data,
  output logic         ovf_evt
);
  logic buf_valid;

  assign out_push = buf_valid && !q_full;
  assign ovf_evt  = in_push && buf_valid && !out_push;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_push) begin
      buf_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_push) begin
      buf_valid <= 1'b0;
    end
  end

  AST_OVF_REPLACE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (buf_valid && out_data == $past(in_data))); // R5
endmodule

// File: rtl/afe_err_flags.sv
module afe_err_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_wdata,
  input  logic         en_wr,
  input  logic [N-1:0] en_wdata,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] irq_en;

  function automatic logic flag_next(input logic cur, input logic set,
                                     input logic wr, input logic keep);
    return set || (cur && !(wr && !keep));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     irq_en <= '0;
    else if (en_wr) irq_en <= en_wdata;
  end

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= flag_next(flags[i], evt[i], clr_wr, clr_wdata[i]);
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> flags[i]); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !(clr_wr && !clr_wdata[i])) |=> flags[i]); // R7
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && !clr_wdata[i] && !evt[i]) |=> !flags[i]); // R7
  end

  assign irq = |(flags & irq_en);

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != '0)); // R9
endmodule

// File: rtl/audio_err_stat.sv
module audio_err_stat #(
  parameter int W        = 16,
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8,
  localparam int TCW     = afe_pkg::cnt_width(TX_DEPTH),
  localparam int RCW     = afe_pkg::cnt_width(RX_DEPTH),
  localparam int STW     = 4 + TCW + RCW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cpu_tx_wr,
  input  logic [W-1:0]             cpu_tx_data,
  input  logic                     cpu_rx_rd,
  output logic [W-1:0]             cpu_rx_data,
  input  logic                     cpu_flag_wr,
  input  logic [afe_pkg::NFLAG-1:0] cpu_flag_wdata,
  input  logic                     cpu_en_wr,
  input  logic [afe_pkg::NFLAG-1:0] cpu_en_wdata,
  output logic [STW-1:0]           stat_rdata,
  output logic                     irq,
  input  logic                     ser_tx_pop,
  output logic [W-1:0]             ser_tx_data,
  output logic                     ser_tx_valid,
  input  logic                     ser_rx_push,
  input  logic [W-1:0]             ser_rx_data
);
  import afe_pkg::*;

  logic [TCW-1:0]   tx_cnt;
  logic [RCW-1:0]   rx_cnt;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic             rx_drain;
  logic [W-1:0]     rx_buf_data;
  logic             tx_ovf_evt, rx_udf_evt, rx_ovf_evt;
  logic [NFLAG-1:0] err_evt, flags;

  assign tx_ovf_evt = cpu_tx_wr && tx_full;
  assign rx_udf_evt = cpu_rx_rd && rx_empty;

  afe_fifo #(.W(W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(cpu_tx_wr), .din(cpu_tx_data),
    .pop(ser_tx_pop), .dout(ser_tx_data),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );
  assign ser_tx_valid = !tx_empty;

  afe_rx_buf #(.W(W)) u_rxbuf (
    .clk(clk), .rst_n(rst_n),
    .in_push(ser_rx_push), .in_data(ser_rx_data),
    .q_full(rx_full), .out_push(rx_drain), .out_data(rx_buf_data),
    .ovf_evt(rx_ovf_evt)
  );

  afe_fifo #(.W(W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(rx_drain), .din(rx_buf_data),
    .pop(cpu_rx_rd), .dout(cpu_rx_data),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  always_comb begin
    err_evt          = '0;
    err_evt[F_TXOVF] = tx_ovf_evt;
    err_evt[F_RXUDF] = rx_udf_evt;
    err_evt[F_RXOVF] = rx_ovf_evt;
  end

  afe_err_flags #(.N(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .evt(err_evt),
    .clr_wr(cpu_flag_wr), .clr_wdata(cpu_flag_wdata),
    .en_wr(cpu_en_wr), .en_wdata(cpu_en_wdata),
    .flags(flags), .irq(irq)
  );

  assign stat_rdata = {rx_cnt, tx_cnt, 1'b0, flags};

  AST_TX_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ovf_evt && !ser_tx_pop) |=> $stable(tx_cnt)); // R3
  AST_UDF_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_udf_evt && !rx_drain) |=> (rx_cnt == '0)); // R4
  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf_evt |=> stat_rdata[F_TXOVF]); // R6
endmodule

// File: tb/sim_audio_err_stat.sv
module sim_audio_err_stat;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cpu_tx_wr = 0, cpu_rx_rd = 0, cpu_flag_wr = 0, cpu_en_wr = 0;
  logic        ser_tx_pop = 0, ser_rx_push = 0;
  logic [15:0] cpu_tx_data = 0, ser_rx_data = 0;
  logic [2:0]  cpu_flag_wdata = 0, cpu_en_wdata = 0;
  logic [15:0] cpu_rx_data, ser_tx_data;
  logic [11:0] stat_rdata;
  logic        irq, ser_tx_valid;

  audio_err_stat u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_tx_wr(cpu_tx_wr), .cpu_tx_data(cpu_tx_data),
    .cpu_rx_rd(cpu_rx_rd), .cpu_rx_data(cpu_rx_data),
    .cpu_flag_wr(cpu_flag_wr), .cpu_flag_wdata(cpu_flag_wdata),
    .cpu_en_wr(cpu_en_wr), .cpu_en_wdata(cpu_en_wdata),
    .stat_rdata(stat_rdata), .irq(irq),
    .ser_tx_pop(ser_tx_pop), .ser_tx_data(ser_tx_data), .ser_tx_valid(ser_tx_valid),
    .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data)
  );

  int n_run = 0, n_fail = 0;

  // reference model
  logic [15:0] txq[$], rxq[$];
  logic        m_bv = 0;
  logic [15:0] m_bd = 0;
  logic [2:0]  m_flags = 0, m_en = 0;

  function automatic logic [11:0] exp_stat();
    return {4'(rxq.size()), 4'(txq.size()), 1'b0, m_flags};
  endfunction

  function automatic logic exp_irq();
    return (m_flags & m_en) != 3'b000;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [2:0] ev;
    logic tfull, rfull, remp, drain;
    tfull = (txq.size() == 8);
    rfull = (rxq.size() == 8);
    remp  = (rxq.size() == 0);
    drain = m_bv && !rfull;
    ev[0] = cpu_tx_wr && tfull;
    ev[1] = cpu_rx_rd && remp;
    ev[2] = ser_rx_push && m_bv && !drain;
    if (ser_tx_pop && txq.size() != 0) void'(txq.pop_front());
    if (cpu_tx_wr && !tfull) txq.push_back(cpu_tx_data);
    if (cpu_rx_rd && !remp) void'(rxq.pop_front());
    if (drain) rxq.push_back(m_bd);
    if (ser_rx_push) begin m_bv = 1; m_bd = ser_rx_data; end
    else if (drain) m_bv = 0;
    m_flags = (cpu_flag_wr ? (m_flags & cpu_flag_wdata) : m_flags) | ev;
    if (cpu_en_wr) m_en = cpu_en_wdata;
  endtask

  task automatic compare_all();
    chk("R2 R11 R10 counts", int'(stat_rdata[11:4]), int'(exp_stat() >> 4));
    chk("R3 R4 R5 R7 flags", int'(stat_rdata[3:0]), int'(exp_stat() & 12'hF));
    chk("R9 irq", int'(irq), int'(exp_irq()));
    chk("R2 tx valid", int'(ser_tx_valid), int'(txq.size() != 0));
    if (txq.size() != 0) chk("R2 tx data", int'(ser_tx_data), int'(txq[0]));
    if (rxq.size() != 0) chk("R11 rx data", int'(cpu_rx_data), int'(rxq[0]));
  endtask

  // inputs are set by the caller at a falling edge; step advances one cycle
  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
    cpu_tx_wr = 0; cpu_rx_rd = 0; cpu_flag_wr = 0; cpu_en_wr = 0;
    ser_tx_pop = 0; ser_rx_push = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0A17));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset stat", int'(stat_rdata), 0);
    chk("R1 reset irq", int'(irq), 0);
    chk("R1 reset tx valid", int'(ser_tx_valid), 0);

    // R2/R3: fill transmit queue then overflow
    for (int i = 0; i < 8; i++) begin
      cpu_tx_wr = 1; cpu_tx_data = 16'hA000 + 16'(i); step();
    end
    chk("R10 tx count field", int'(stat_rdata[7:4]), 8);
    cpu_tx_wr = 1; cpu_tx_data = 16'hDEAD; step();
    chk("R3 tx overflow flag", int'(stat_rdata[0]), 1);
    chk("R6 no irq with mask 0", int'(irq), 0);
    chk("R3 head unchanged", int'(ser_tx_data), 16'hA000);
    for (int i = 0; i < 8; i++) begin
      chk("R3 stored word", int'(ser_tx_data), 16'hA000 + i);
      ser_tx_pop = 1; step();
    end
    chk("R2 empty after drain", int'(ser_tx_valid), 0);

    // R9: enable, then R7 write-1 keeps, write-0 clears
    cpu_en_wr = 1; cpu_en_wdata = 3'b001; step();
    chk("R9 irq with enable", int'(irq), 1);
    cpu_flag_wr = 1; cpu_flag_wdata = 3'b111; step();
    chk("R7 write 1 keeps", int'(stat_rdata[0]), 1);
    cpu_flag_wr = 1; cpu_flag_wdata = 3'b110; step();
    chk("R7 write 0 clears", int'(stat_rdata[0]), 0);
    chk("R9 irq drops", int'(irq), 0);

    // R4 underflow, R8 set wins over clear
    cpu_rx_rd = 1; step();
    chk("R4 underflow flag", int'(stat_rdata[1]), 1);
    chk("R4 rx count stays 0", int'(stat_rdata[11:8]), 0);
    cpu_rx_rd = 1; cpu_flag_wr = 1; cpu_flag_wdata = 3'b000; step();
    chk("R8 set wins", int'(stat_rdata[1]), 1);

    // R11 latency: word shows in count two edges after strobe
    ser_rx_push = 1; ser_rx_data = 16'h1111; step();
    chk("R11 count after one edge", int'(stat_rdata[11:8]), 0);
    step();
    chk("R11 count after two edges", int'(stat_rdata[11:8]), 1);
    chk("R11 rx word", int'(cpu_rx_data), 16'h1111);

    // R5: fill receive queue, then overflow the holding buffer
    for (int i = 1; i < 8; i++) begin
      ser_rx_push = 1; ser_rx_data = 16'h2000 + 16'(i); step();
    end
    idle(1);
    ser_rx_push = 1; ser_rx_data = 16'h3333; step();
    ser_rx_push = 1; ser_rx_data = 16'h4444; step();
    chk("R5 rx overflow flag", int'(stat_rdata[2]), 1);
    for (int i = 0; i < 8; i++) begin cpu_rx_rd = 1; step(); end
    idle(1);
    chk("R5 newer word kept", int'(cpu_rx_data), 16'h4444);
    cpu_en_wr = 1; cpu_en_wdata = 3'b100; step();
    chk("R9 irq from rx overflow", int'(irq), 1);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      cpu_tx_wr   = ($urandom_range(99) < 45);
      cpu_tx_data = 16'($urandom());
      ser_tx_pop  = ($urandom_range(99) < 35);
      ser_rx_push = ($urandom_range(99) < 45);
      ser_rx_data = 16'($urandom());
      cpu_rx_rd   = ($urandom_range(99) < 35);
      cpu_flag_wr = ($urandom_range(99) < 12);
      cpu_flag_wdata = 3'($urandom());
      cpu_en_wr   = ($urandom_range(99) < 6);
      cpu_en_wdata = 3'($urandom());
      step();
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule